// File: doc/BRIEF.md
# Oscillator Frequency Window Detector

This block decides whether a recovered-clock oscillator is running close enough to its nominal rate for the bang-bang phase loop to be trusted. It divides the oscillator down to the reference rate and counts the divided edges over a fixed number of reference cycles. It then judges the count against a tolerance band that corresponds to roughly ±1000 ppm. The reference may be a cheap crystal source at 38.88 MHz or 19.44 MHz. The compare divider follows that choice, ÷64 or ÷128 from a 2488.32 MHz oscillator. A separate line-rate divider of ÷4 or ÷16 produces a bit-rate strobe for 622.08 Mb/s or 155.52 Mb/s operation.

A small state machine in the oscillator domain turns the measurement verdicts into a lock flag, a phase-detector disable and a coarse steer request. The machine has five states. `ST_NOREF` means the reference is absent. `ST_HUNT` means hunting with no good verdict yet. `ST_HUNT_ONE` means one good verdict has been seen. `ST_LOCK` means locked. `ST_LOCK_MISS` means locked with one bad verdict.

The transitions are:
- A lost reference sends every state to `ST_NOREF`, and this rule takes priority over all others.
- `ST_NOREF` moves to `ST_HUNT` once reference edges return.
- `ST_HUNT` moves to `ST_HUNT_ONE` on an in-window verdict.
- `ST_HUNT_ONE` moves to `ST_LOCK` on a second in-window verdict, or back to `ST_HUNT` on an out-of-window one.
- `ST_LOCK` moves to `ST_LOCK_MISS` on an out-of-window verdict.
- `ST_LOCK_MISS` returns to `ST_LOCK` on an in-window verdict, or drops to `ST_HUNT` on a second bad one.

The divided-edge counter crosses into the reference domain in Gray code through a two-flop synchronizer. Each verdict returns to the oscillator domain as a toggle with its 2-bit code held stable beside it. By default a measurement spans 4096 reference cycles with a tolerance of ±4 counts (about 977 ppm). Two agreeing measurements at 38.88 MHz therefore take about 210 µs.

Top module: `freq_window_det`

## Requirements
- R1: While reset is asserted, and after release until the first verdict, lock=0, pd_off=1, steer_up=0 and steer_dn=0.
- R2: A measurement counts divided-oscillator edges over 2^MEAS_LOG2 reference cycles. The verdict is in window when the count lies within NOMINAL±TOL inclusive, where NOMINAL=2^MEAS_LOG2. It is fast above that band and slow below it.
- R3: The compare divider is ÷64 when ref_sel=0 (38.88 MHz reference) and ÷128 when ref_sel=1 (19.44 MHz reference).
- R4: bit_stb is a one-cycle pulse every 4 oscillator cycles when rate_sel=1 (622.08 Mb/s) and every 16 cycles when rate_sel=0 (155.52 Mb/s).
- R5: lock rises only after two consecutive in-window verdicts.
- R6: While locked, a single out-of-window verdict leaves lock high with no steering. Two consecutive ones drop lock.
- R7: While unlocked with a reference present, steer_dn=1 after a fast verdict, steer_up=1 after a slow verdict, and both are 0 after an in-window verdict. steer_up and steer_dn are never high together, and both are 0 while locked.
- R8: pd_off is high exactly when lock is low.
- R9: If no reference edge is seen for NOREF_LIM divided-oscillator cycles, lock falls on the next cycle and the outputs become pd_off=1, steer_up=1, steer_dn=0. A shorter gap has no effect.
- R10: Changing rate_sel does not disturb the measurement or the lock flag.
- R11: After the reference returns, lock stays low until two new consecutive in-window verdicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock (nominal 2488.32 MHz) |
| ref_clk | input | 1 | Low-precision reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rate_sel | input | 1 | 1: 622.08 Mb/s line divider ÷4; 0: 155.52 Mb/s ÷16 |
| ref_sel | input | 1 | 0: 38.88 MHz reference (÷64); 1: 19.44 MHz (÷128) |
| bit_stb | output | 1 | Line-rate strobe in the oscillator domain |
| lock | output | 1 | Reference present and oscillator within window |
| pd_off | output | 1 | Phase-detector disable |
| steer_up | output | 1 | Coarse request to raise oscillator frequency |
| steer_dn | output | 1 | Coarse request to lower oscillator frequency |

## Verification
The line-rate divider and the compare path both run on every oscillator cycle. A change of rate_sel therefore lands in the same cycle as a divided-edge count increment. The bench flips rate_sel while the loop is locked and measures the new strobe spacing at the port. It then requires lock to stay high over the following measurement windows.

A second overlap is a reference pause that is shorter than the loss limit. That pause makes one verdict an outlier while the watchdog is already counting. The bench judges that lock never drops and that no steering appears.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        V_IN   = 2'b00,
        V_SLOW = 2'b01,
        V_FAST = 2'b10
    } verdict_e;

    typedef enum logic [2:0] {
        ST_NOREF,
        ST_HUNT,
        ST_HUNT_ONE,
        ST_LOCK,
        ST_LOCK_MISS
    } lock_st_e;

endpackage

// File: rtl/fwd_sync.sv
module fwd_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_st
            logic [W-1:0] r;
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) r <= '0;
                    else        r <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) r <= '0;
                    else        r <= g_st[g-1].r;
                end
            end
        end
    endgenerate

    assign q = g_st[STAGES-1].r;
endmodule

// File: rtl/fwd_osc_div.sv
module fwd_osc_div #(
    parameter int LINE_FAST = 4,
    parameter int LINE_SLOW = 16,
    parameter int CMP_HI    = 64,
    parameter int CMP_LO    = 128,
    parameter int CNT_W     = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rate_sel,
    input  logic             ref_sel,
    output logic             bit_stb,
    output logic             div_tick,
    output logic [CNT_W-1:0] gray_q
);
    localparam int LMAX = (LINE_SLOW > LINE_FAST) ? LINE_SLOW : LINE_FAST;
    localparam int PMAX = (CMP_LO > CMP_HI) ? CMP_LO : CMP_HI;
    localparam int LW   = $clog2(LMAX);
    localparam int PW   = $clog2(PMAX);

    logic [LW-1:0]    line_cnt, line_last;
    logic [PW-1:0]    pre_cnt, pre_last;
    logic [CNT_W-1:0] bin_q, bin_nxt;
    logic             pre_wrap, line_wrap;

    assign line_last = rate_sel ? LW'(LINE_FAST - 1) : LW'(LINE_SLOW - 1);
    assign pre_last  = ref_sel  ? PW'(CMP_LO - 1)    : PW'(CMP_HI - 1);
    assign line_wrap = (line_cnt >= line_last);
    assign pre_wrap  = (pre_cnt >= pre_last);
    assign bin_nxt   = bin_q + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_cnt <= '0;
            bit_stb  <= 1'b0;
        end else begin
            line_cnt <= line_wrap ? '0 : line_cnt + LW'(1);
            bit_stb  <= line_wrap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            div_tick <= 1'b0;
            bin_q    <= '0;
            gray_q   <= '0;
        end else begin
            pre_cnt  <= pre_wrap ? '0 : pre_cnt + PW'(1);
            div_tick <= pre_wrap;
            if (pre_wrap) begin
                bin_q  <= bin_nxt;
                gray_q <= bin_nxt ^ (bin_nxt >> 1);
            end
        end
    end
endmodule

// File: rtl/fwd_meas.sv
module fwd_meas
    import fwd_pkg::*;
#(
    parameter int MEAS_LOG2 = 12,
    parameter int TOL       = 4,
    parameter int CNT_W     = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] gray_in,
    output verdict_e         verdict,
    output logic             vld_tgl,
    output logic             ref_tgl
);
    localparam logic [CNT_W-1:0] NOM = CNT_W'(1) << MEAS_LOG2;
    localparam logic [CNT_W-1:0] HI  = NOM + CNT_W'(TOL);
    localparam logic [CNT_W-1:0] LO  = NOM - CNT_W'(TOL);

    logic [CNT_W-1:0]     gray_s, cur_bin, snap, delta;
    logic [MEAS_LOG2-1:0] win_cnt;

    function automatic logic [CNT_W-1:0] to_bin(input logic [CNT_W-1:0] g);
        logic [CNT_W-1:0] b;
        b = g;
        for (int i = 1; i < CNT_W; i++) b = b ^ (g >> i);
        return b;
    endfunction

    fwd_sync #(.W(CNT_W), .STAGES(2)) u_gsync (
        .clk(clk), .rst_n(rst_n), .d(gray_in), .q(gray_s)
    );

    assign cur_bin = to_bin(gray_s);
    assign delta   = cur_bin - snap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt <= '0;
            snap    <= '0;
            verdict <= V_IN;
            vld_tgl <= 1'b0;
            ref_tgl <= 1'b0;
        end else begin
            ref_tgl <= ~ref_tgl;
            win_cnt <= win_cnt + MEAS_LOG2'(1);
            if (&win_cnt) begin
                snap    <= cur_bin;
                vld_tgl <= ~vld_tgl;
                if (delta > HI)      verdict <= V_FAST;
                else if (delta < LO) verdict <= V_SLOW;
                else                 verdict <= V_IN;
            end
        end
    end
endmodule

// File: rtl/fwd_lock_ctl.sv
module fwd_lock_ctl
    import fwd_pkg::*;
#(
    parameter int NOREF_LIM = 256
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     div_tick,
    input  logic     ref_tgl_s,
    input  logic     vld_tgl_s,
    input  verdict_e verdict_a,
    output logic     vstb,
    output logic     ref_lost,
    output logic     lock,
    output logic     pd_off,
    output logic     steer_up,
    output logic     steer_dn
);
    localparam int WD_W = $clog2(NOREF_LIM + 1);

    lock_st_e        st, st_nxt;
    logic            ref_prev, vld_prev;
    logic [WD_W-1:0] wd_cnt;
    logic [1:0]      dir_q;
    logic            good;

    assign vstb     = vld_tgl_s ^ vld_prev;
    assign ref_lost = (wd_cnt == WD_W'(NOREF_LIM));
    assign good     = (verdict_a == V_IN);

    // reference watchdog and last steering direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_prev <= 1'b0;
            vld_prev <= 1'b0;
            wd_cnt   <= '0;
            dir_q    <= 2'b00;
        end else begin
            ref_prev <= ref_tgl_s;
            vld_prev <= vld_tgl_s;
            if (ref_tgl_s != ref_prev)   wd_cnt <= '0;
            else if (div_tick && !ref_lost) wd_cnt <= wd_cnt + WD_W'(1);
            if (vstb) begin
                unique case (verdict_a)
                    V_SLOW:  dir_q <= 2'b10;
                    V_FAST:  dir_q <= 2'b01;
                    default: dir_q <= 2'b00;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_HUNT;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        if (ref_lost) begin
            st_nxt = ST_NOREF;
        end else begin
            unique case (st)
                ST_NOREF:     st_nxt = ST_HUNT;
                ST_HUNT:      if (vstb && good) st_nxt = ST_HUNT_ONE;
                ST_HUNT_ONE:  if (vstb) st_nxt = good ? ST_LOCK : ST_HUNT;
                ST_LOCK:      if (vstb && !good) st_nxt = ST_LOCK_MISS;
                ST_LOCK_MISS: if (vstb) st_nxt = good ? ST_LOCK : ST_HUNT;
                default:      st_nxt = ST_HUNT;
            endcase
        end
    end

    // outputs
    always_comb begin
        lock     = 1'b0;
        pd_off   = 1'b1;
        steer_up = 1'b0;
        steer_dn = 1'b0;
        unique case (st)
            ST_NOREF: begin
                steer_up = 1'b1;
            end
            ST_HUNT, ST_HUNT_ONE: begin
                steer_up = dir_q[1];
                steer_dn = dir_q[0];
            end
            ST_LOCK, ST_LOCK_MISS: begin
                lock   = 1'b1;
                pd_off = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/freq_window_det.sv
module freq_window_det
    import fwd_pkg::*;
#(
    parameter int MEAS_LOG2 = 12,
    parameter int TOL       = 4,
    parameter int NOREF_LIM = 256,
    parameter int LINE_FAST = 4,
    parameter int LINE_SLOW = 16,
    parameter int CMP_HI    = 64,
    parameter int CMP_LO    = 128
) (
    input  logic osc_clk,
    input  logic ref_clk,
    input  logic rst_n,
    input  logic rate_sel,
    input  logic ref_sel,
    output logic bit_stb,
    output logic lock,
    output logic pd_off,
    output logic steer_up,
    output logic steer_dn
);
    localparam int CNT_W = MEAS_LOG2 + 2;

    logic [CNT_W-1:0] gray_q;
    logic             div_tick, vld_tgl, ref_tgl, vld_tgl_s, ref_tgl_s;
    logic             vstb, ref_lost;
    verdict_e         verdict;

    fwd_osc_div #(
        .LINE_FAST(LINE_FAST), .LINE_SLOW(LINE_SLOW),
        .CMP_HI(CMP_HI), .CMP_LO(CMP_LO), .CNT_W(CNT_W)
    ) u_div (
        .clk(osc_clk), .rst_n(rst_n), .rate_sel(rate_sel), .ref_sel(ref_sel),
        .bit_stb(bit_stb), .div_tick(div_tick), .gray_q(gray_q)
    );

    fwd_meas #(.MEAS_LOG2(MEAS_LOG2), .TOL(TOL), .CNT_W(CNT_W)) u_meas (
        .clk(ref_clk), .rst_n(rst_n), .gray_in(gray_q),
        .verdict(verdict), .vld_tgl(vld_tgl), .ref_tgl(ref_tgl)
    );

    fwd_sync #(.W(2), .STAGES(2)) u_tsync (
        .clk(osc_clk), .rst_n(rst_n),
        .d({vld_tgl, ref_tgl}), .q({vld_tgl_s, ref_tgl_s})
    );

    fwd_lock_ctl #(.NOREF_LIM(NOREF_LIM)) u_ctl (
        .clk(osc_clk), .rst_n(rst_n), .div_tick(div_tick),
        .ref_tgl_s(ref_tgl_s), .vld_tgl_s(vld_tgl_s), .verdict_a(verdict),
        .vstb(vstb), .ref_lost(ref_lost), .lock(lock), .pd_off(pd_off),
        .steer_up(steer_up), .steer_dn(steer_dn)
    );
endmodule

// File: rtl/fwd_chk.sv
module fwd_chk (
    input logic clk,
    input logic rst_n,
    input logic lock,
    input logic steer_up,
    input logic steer_dn,
    input logic bit_stb,
    input logic vstb,
    input logic ref_lost
);
    // R7
    steer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(steer_up && steer_dn));

    // R7
    lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> (!steer_up && !steer_dn));

    // R9
    noref_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_lost |=> !lock);

    // R5
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(vstb));

    // R6
    lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock) |-> $past(vstb || ref_lost));

    // R4
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);
endmodule

bind freq_window_det fwd_chk u_chk (
    .clk(osc_clk), .rst_n(rst_n), .lock(lock), .steer_up(steer_up),
    .steer_dn(steer_dn), .bit_stb(bit_stb), .vstb(vstb), .ref_lost(ref_lost)
);

// File: tb/sim_freq_window_det.sv
`timescale 1ns/1ps
module sim_freq_window_det;
    localparam realtime OSC_PERIOD = 2.0;
    localparam int MEAS_LOG2 = 5;
    localparam int TOL       = 1;
    localparam int NOREF_LIM = 16;

    typedef struct packed {
        int   half_ps;
        logic rsel;
        logic e_lock;
        logic e_up;
        logic e_dn;
    } vec_t;

    // ref half period in ps, ref_sel, expected lock/up/dn
    localparam vec_t VECS [6] = '{
        '{70000,  1'b0, 1'b0, 1'b0, 1'b1},   // R2 fast -> R7 steer_dn
        '{64300,  1'b0, 1'b1, 1'b0, 1'b0},   // R2 in window -> R5 lock
        '{58000,  1'b0, 1'b0, 1'b1, 1'b0},   // R6 drop, R7 steer_up
        '{64000,  1'b1, 1'b0, 1'b1, 1'b0},   // R3 div 128 makes count half
        '{128400, 1'b1, 1'b1, 1'b0, 1'b0},   // R3 19.44 reference locks
        '{140000, 1'b1, 1'b0, 1'b0, 1'b1}    // R3 fast with div 128
    };

    logic osc_clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
    logic rate_sel = 1'b1, ref_sel = 1'b0, ref_run = 1'b1;
    real  ref_half = 70.0;
    int   n_chk = 0, n_fail = 0;
    logic bit_stb, lock, pd_off, steer_up, steer_dn;

    always #(OSC_PERIOD / 2.0) osc_clk = ~osc_clk;
    initial forever begin
        #(ref_half);
        if (ref_run) ref_clk = ~ref_clk;
    end

    freq_window_det #(.MEAS_LOG2(MEAS_LOG2), .TOL(TOL), .NOREF_LIM(NOREF_LIM)) u0 (
        .osc_clk(osc_clk), .ref_clk(ref_clk), .rst_n(rst_n),
        .rate_sel(rate_sel), .ref_sel(ref_sel), .bit_stb(bit_stb),
        .lock(lock), .pd_off(pd_off), .steer_up(steer_up), .steer_dn(steer_dn)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {lock,pd_off,up,dn} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wait_windows(input int n);
        #(n * (2.0 ** MEAS_LOG2) * 2.0 * ref_half);
        @(negedge osc_clk);
    endtask

    function automatic logic [3:0] outs();
        return {lock, pd_off, steer_up, steer_dn};
    endfunction

    task automatic count_stb(input string req, input int exp);
        int n = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge osc_clk);
            if (bit_stb) n++;
        end
        n_chk++;
        if (n != exp) begin
            n_fail++;
            $display("FAIL %s: strobes in 64 cycles actual %0d expected %0d", req, n, exp);
        end
    endtask

    initial begin
        #(400000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int bad;
        // R1 during and after reset
        #50;
        check("R1 in reset", outs(), 4'b0100);
        #50;
        rst_n = 1'b1;
        #1000;
        @(negedge osc_clk);
        check("R1 after release", outs(), 4'b0100);

        // table walk: R2 R3 R5 R6 R7 R8
        for (int v = 0; v < 6; v++) begin
            ref_half = VECS[v].half_ps / 1000.0;
            ref_sel  = VECS[v].rsel;
            wait_windows(4);
            check($sformatf("R2/R7 row %0d", v), outs(),
                  {VECS[v].e_lock, ~VECS[v].e_lock, VECS[v].e_up, VECS[v].e_dn});
            n_chk++;
            if (pd_off !== ~lock) begin
                n_fail++;
                $display("FAIL R8 row %0d: pd_off actual %b expected %b", v, pd_off, ~lock);
            end
        end

        // back to 38.88 in window
        ref_sel  = 1'b0;
        ref_half = 64.3;
        wait_windows(4);
        check("R5 relock", outs(), 4'b1000);

        // R4 strobe spacing, R10 rate change leaves lock
        @(negedge osc_clk);
        count_stb("R4 rate_sel=1", 16);
        rate_sel = 1'b0;
        count_stb("R4 rate_sel=0", 4);
        wait_windows(3);
        check("R10 lock after rate change", outs(), 4'b1000);
        rate_sel = 1'b1;

        // R6 single outlier from short reference pause
        bad = 0;
        ref_run = 1'b0;
        for (int i = 0; i < 10; i++) begin
            #100;
            if (outs() !== 4'b1000) bad++;
        end
        ref_run = 1'b1;
        for (int i = 0; i < 160; i++) begin
            #100;
            if (outs() !== 4'b1000) bad++;
        end
        n_chk++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL R6 outlier: bad samples actual %0d expected 0", bad);
        end

        // R9 reference loss
        ref_run = 1'b0;
        #1200;
        @(negedge osc_clk);
        check("R9 before limit", outs(), 4'b1000);
        #2500;
        @(negedge osc_clk);
        check("R9 after limit", outs(), 4'b0110);

        // R11 reacquire
        ref_run = 1'b1;
        #500;
        @(negedge osc_clk);
        check("R11 no early lock", outs(), 4'b0100);
        wait_windows(5);
        check("R11 relock", outs(), 4'b1000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule